// File: doc/BRIEF.md
# Segmented DAC Input Decoder

This block is the digital front end of a 14-bit current-steering converter. On each converter clock it registers a straight-binary sample. It then splits the sample into a 5-bit upper segment and a 9-bit lower segment. The upper segment is turned into 31 thermometer switch lines, and the lower segment passes on as binary-weighted switch bits. Both segments travel through a fixed three-register pipeline, so every sample reaches the switch outputs with the same latency.

An active-low reset input also acts as a burst control. Pulling it low clears the switch outputs at once, without waiting for a clock edge, which forces the minimum code whatever data is present. A differential standby pair is decoded into a registered power-down flag. While that flag is set, the switch outputs are held at the zero code.

Top module: `seg_dac_decoder`

## Requirements
- R1: The input code is straight binary. Code 0x0000 gives all outputs zero (minus full scale). Code 0x3FFF gives all 31 unary lines and all 9 binary bits set (plus full scale).
- R2: `binary_o` carries bits [8:0] of the sample, unchanged.
- R3: `unary_o[j]` is 1 exactly when j is less than the value of sample bits [13:9]. The set lines therefore always form a contiguous run starting at bit 0.
- R4: A sample on `code_i` at rising edge t appears on the outputs just after rising edge t+2, which is the third edge to capture it. The output weight, 512 times the count of set unary lines plus `binary_o`, equals that sample.
- R5: While `rst_ni` is low, `unary_o`, `binary_o` and `standby_o` are zero. They become zero without any clock edge, whatever `code_i` holds.
- R6: Reset clears every pipeline stage. After `rst_ni` rises, the first rising edge captures a sample with no extra settling cycle. Until that sample arrives, the outputs stay zero.
- R7: At a rising edge, the pair `standby_p_i`=1 / `standby_n_i`=0 sets `standby_o`. The pair 0/1 clears it.
- R8: At a rising edge, an equal pair (0/0 or 1/1) leaves `standby_o` unchanged.
- R9: While `standby_o` is 1, the next rising edge loads the zero code into the outputs. The pipeline keeps running, so after standby clears, the outputs resume with the sample that is then due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Active-low asynchronous reset and burst control |
| code_i | input | 14 | Straight-binary sample |
| standby_p_i | input | 1 | Standby request, true side |
| standby_n_i | input | 1 | Standby request, complement side |
| unary_o | output | 31 | Thermometer switch lines for the upper segment |
| binary_o | output | 9 | Binary switch bits for the lower segment |
| standby_o | output | 1 | Registered power-down flag |

## Verification
The clocked properties assume that `code_i` and the standby pair are stable around each rising edge. They also assume that a latency check is made only after four clean edges since the last reset, a condition the checker tracks with its own small counter. The bench keeps within these assumptions by changing every input on the falling edge, including the burst reset, so no input ever moves near a capture edge. The async-clear property samples on the falling edge, which lets it see a reset that was applied partway through the previous cycle.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;

  typedef enum logic {
    SB_RUN   = 1'b0,
    SB_SLEEP = 1'b1
  } sb_mode_e;

  // equal pair is invalid: hold mode
  function automatic sb_mode_e sb_next(sb_mode_e cur, logic p, logic n);
    case ({p, n})
      2'b10:   return SB_SLEEP;
      2'b01:   return SB_RUN;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/seg_dac_stage.sv
module seg_dac_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else            q_o <= d_i;
  end

endmodule

// File: rtl/seg_dac_therm.sv
module seg_dac_therm #(
  parameter int SEG_W = 5,
  localparam int LINES = (1 << SEG_W) - 1
) (
  input  logic [SEG_W-1:0] seg_i,
  output logic [LINES-1:0] therm_o
);

  for (genvar j = 0; j < LINES; j++) begin : g_line
    assign therm_o[j] = (int'(seg_i) > j);
  end

endmodule

// File: rtl/seg_dac_standby.sv
module seg_dac_standby
  import seg_dac_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sb_p_i,
  input  logic     sb_n_i,
  output sb_mode_e mode_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= SB_RUN;
    else         mode_o <= sb_next(mode_o, sb_p_i, sb_n_i);
  end

endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import seg_dac_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int UNARY_W = 5,
  localparam int BIN_W   = DATA_W - UNARY_W,
  localparam int THERM_W = (1 << UNARY_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  code_i,
  input  logic               standby_p_i,
  input  logic               standby_n_i,
  output logic [THERM_W-1:0] unary_o,
  output logic [BIN_W-1:0]   binary_o,
  output logic               standby_o
);

  localparam int SW_W = THERM_W + BIN_W;

  logic [DATA_W-1:0]  cap_q;
  logic [THERM_W-1:0] therm_d;
  logic [SW_W-1:0]    dec_q;
  logic [SW_W-1:0]    out_q;
  sb_mode_e           mode_q;

  // stage 1: sample capture
  seg_dac_stage #(.W(DATA_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (1'b0),
    .d_i   (code_i),
    .q_o   (cap_q)
  );

  seg_dac_therm #(.SEG_W(UNARY_W)) u_therm (
    .seg_i  (cap_q[DATA_W-1 -: UNARY_W]),
    .therm_o(therm_d)
  );

  // stage 2: decoded segments
  seg_dac_stage #(.W(SW_W)) u_dec (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (1'b0),
    .d_i   ({therm_d, cap_q[BIN_W-1:0]}),
    .q_o   (dec_q)
  );

  seg_dac_standby u_sb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sb_p_i(standby_p_i),
    .sb_n_i(standby_n_i),
    .mode_o(mode_q)
  );

  // stage 3: switch drive, zeroed in standby
  seg_dac_stage #(.W(SW_W)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (mode_q == SB_SLEEP),
    .d_i   (dec_q),
    .q_o   (out_q)
  );

  assign unary_o   = out_q[SW_W-1 -: THERM_W];
  assign binary_o  = out_q[BIN_W-1:0];
  assign standby_o = (mode_q == SB_SLEEP);

endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk #(
  parameter int DATA_W  = 14,
  parameter int UNARY_W = 5,
  localparam int BIN_W   = DATA_W - UNARY_W,
  localparam int THERM_W = (1 << UNARY_W) - 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [DATA_W-1:0]  code_i,
  input logic               standby_p_i,
  input logic               standby_n_i,
  input logic [THERM_W-1:0] unary_o,
  input logic [BIN_W-1:0]   binary_o,
  input logic               standby_o
);

  logic [2:0]        cyc_q;
  logic [DATA_W-1:0] weight;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
  end

  always_comb weight = DATA_W'(($countones(unary_o) << BIN_W) + int'(binary_o));

  p_therm_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((unary_o + 1'b1) & unary_o) == '0);

  p_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 3'd4 && !$past(standby_o)) |-> weight == $past(code_i, 3));

  p_burst_zero_r5: assert property (@(negedge clk_i)
    !rst_ni |-> (unary_o == '0 && binary_o == '0 && !standby_o));

  p_sb_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_p_i && !standby_n_i) |=> standby_o);

  p_sb_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_p_i && standby_n_i) |=> !standby_o);

  p_sb_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_p_i == standby_n_i) |=> $stable(standby_o));

  p_sb_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |=> (unary_o == '0 && binary_o == '0));

endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(
  .DATA_W (DATA_W),
  .UNARY_W(UNARY_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .code_i     (code_i),
  .standby_p_i(standby_p_i),
  .standby_n_i(standby_n_i),
  .unary_o    (unary_o),
  .binary_o   (binary_o),
  .standby_o  (standby_o)
);

// File: tb/seg_dac_decoder_tb.sv
`timescale 1ns/1ps
module seg_dac_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] code = '0;
  logic        sb_p = 1'b0;
  logic        sb_n = 1'b1;
  logic [30:0] unary;
  logic [8:0]  binary;
  logic        standby;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [13:0] code;
    string       tag;
  } ent_t;

  typedef struct {
    logic [13:0] code;
    logic        sb;
    string       dtag;
    string       stag;
  } exp_t;

  exp_t exp_q[$];
  ent_t m1, m2;
  logic msb = 1'b0;

  always #2.5 clk = ~clk;

  seg_dac_decoder u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .code_i     (code),
    .standby_p_i(sb_p),
    .standby_n_i(sb_n),
    .unary_o    (unary),
    .binary_o   (binary),
    .standby_o  (standby)
  );

  function automatic logic [30:0] therm_of(logic [4:0] k);
    logic [30:0] t = '0;
    for (int j = 0; j < 31; j++) if (j < int'(k)) t[j] = 1'b1;
    return t;
  endfunction

  task automatic chk(string tag, string what, logic [30:0] act, logic [30:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor side: compare outputs against the oldest expected item
  task automatic compare_front();
    exp_t e;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    chk(e.dtag, "unary", unary, therm_of(e.code[13:9]));
    chk(e.dtag, "binary", {22'd0, binary}, {22'd0, e.code[8:0]});
    chk(e.stag, "standby", {30'd0, standby}, {30'd0, e.sb});
  endtask

  // driver side: drive one cycle of inputs, push the expected result
  task automatic step(logic [13:0] c, logic p, logic n, logic r, string tag);
    exp_t o;
    @(negedge clk);
    compare_front();
    code = c; sb_p = p; sb_n = n; rst_n = r;
    if (!r) begin
      #1;
      chk("R5", "async unary", unary, '0);
      chk("R5", "async binary", {22'd0, binary}, '0);
      chk("R5", "async standby", {30'd0, standby}, '0);
      m1 = '{14'd0, "R6"}; m2 = '{14'd0, "R6"}; msb = 1'b0;
      o = '{14'd0, 1'b0, "R5", "R5"};
    end else begin
      o.code = msb ? 14'd0 : m2.code;
      o.dtag = msb ? "R9" : m2.tag;
      m2 = m1;
      m1 = '{c, tag};
      if (p && !n)      msb = 1'b1;
      else if (!p && n) msb = 1'b0;
      o.sb   = msb;
      o.stag = (p == n) ? "R8" : "R7";
    end
    exp_q.push_back(o);
  endtask

  task automatic run(logic [13:0] c, string tag);
    step(c, 1'b0, 1'b1, 1'b1, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m1 = '{14'd0, "R6"};
    m2 = '{14'd0, "R6"};
    // reset state, with live data on the input (R5)
    @(negedge clk);
    chk("R5", "reset unary", unary, '0);
    chk("R5", "reset standby", {30'd0, standby}, '0);
    for (int i = 0; i < 3; i++) step(14'h3FFF, 1'b1, 1'b0, 1'b0, "R5");

    // release: first edge captures immediately (R6)
    run(14'h3FFF, "R6");
    run(14'h0000, "R1");
    run(14'h3FFF, "R1");
    run(14'h01FF, "R2");
    run(14'h0200, "R3");
    run(14'h3E00, "R3");
    run(14'h1FFF, "R3");
    run(14'h2000, "R4");
    for (int i = 0; i < 300; i++) run(14'($urandom), "R4");

    // standby enter, invalid pairs hold, exit (R7 R8 R9)
    step(14'h2AAA, 1'b1, 1'b0, 1'b1, "R9");
    for (int i = 0; i < 3; i++) step(14'($urandom), 1'b1, 1'b1, 1'b1, "R9");
    for (int i = 0; i < 3; i++) step(14'($urandom), 1'b0, 1'b0, 1'b1, "R9");
    step(14'h1555, 1'b0, 1'b1, 1'b1, "R9");
    // invalid pairs while running keep normal mode (R8)
    for (int i = 0; i < 4; i++) step(14'($urandom), 1'b1, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 4; i++) step(14'($urandom), 1'b0, 1'b0, 1'b1, "R8");

    // burst pulses mid-stream, then release straight into data (R5 R6)
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 5; i++) run(14'($urandom), "R4");
      step(14'h3FFF, 1'b0, 1'b1, 1'b0, "R5");
      run(14'($urandom), "R6");
      run(14'($urandom), "R6");
    end

    // mixed traffic with random standby pairs
    for (int i = 0; i < 400; i++) begin
      logic [1:0] pr = 2'($urandom);
      if (pr == 2'b10 && ($urandom % 4) != 0) pr = 2'b01;
      step(14'($urandom), pr[1], pr[0], 1'b1, "R4");
    end

    for (int i = 0; i < 4; i++) run(14'h0000, "R4");
    @(negedge clk);
    compare_front();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule